// File: doc/BRIEF.md
# Pipelined Late-Write Synchronous SRAM Model

This block is a synthesizable behavioural memory for controller testbenches. It behaves like a pipelined synchronous SRAM in which read and write commands can follow each other on every clock with no idle cycles between them. A command is taken on a rising edge together with its address and byte-lane mask. Read data is driven two enabled edges later. Write data is taken from the data input two enabled edges after its address, so a write occupies the same pipeline slot as a read would.

An internal two-bit counter lets a single loaded address start a four-beat burst. The burst wraps within its aligned group of four words and keeps the direction it was started with. Three chip selects, a clock-enable stall, a snooze input and an asynchronous output enable complete the interface. The data bus is split into an input, an output and a drive-enable flag, so no tristate pad is modelled.

Top module: `pipe_sram`

## Requirements
- R1: A read command taken at enabled edge E0 places the stored word on `dout`, with `dout_en` high, after the second enabled edge following E0. It stays there until the next enabled edge. A command is a read when `rd_wr_n`=1 and a write when `rd_wr_n`=0.
- R2: A write command taken at edge E0 stores `din` as it stands at the second enabled edge after E0. Byte lane i is bits [i*LANE_W +: LANE_W]. It is written only when `ben_n[i]` was 0 at E0. Lanes whose bit was 1 keep their old contents.
- R3: Reads and writes may alternate on consecutive edges. A read of an address issued on the edge after a write to that address returns the newly written data.
- R4: With `ld_n`=1 and a burst active, the counter advances and the word accessed is {upper bits of the loaded address, (loaded low two bits + k) mod 4} on the k-th continue. `rd_wr_n` is ignored on continue edges. `ben_n` is taken on every edge.
- R5: Chip selects are sampled only when `ld_n`=0. The device is selected only when `cs1_n`=0, `cs2_n`=0 and `cs3`=1. A deselected load makes no access.
- R6: A continue edge that follows a deselected load makes no access, and the burst counter does not move.
- R7: While `cken_n`=1, rising edges are ignored. Pipeline, burst counter and outputs hold, and operation resumes as though the stalled cycles never occurred.
- R8: While `sleep`=1, all other inputs are ignored, the pipeline holds, memory contents are retained and `dout_en` is low.
- R9: `oe_n`=1 forces `dout_en` low and `dout` to zero at once, without a clock. It does not disturb the pipeline.
- R10: While `rst_n`=0, pending commands and the burst are cleared and `dout_en` is low. Memory contents are not reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of pipeline and burst state |
| cken_n | input | 1 | Active-low clock enable; high stalls everything |
| sleep | input | 1 | Active-high snooze; ignores all other inputs |
| ld_n | input | 1 | Low loads a new address, high continues a burst |
| rd_wr_n | input | 1 | 1 read, 0 write; used on load edges only |
| addr | input | ADDR_W | Word address |
| ben_n | input | LANES | Active-low byte-lane write mask, given with the address |
| cs1_n | input | 1 | Active-low chip select |
| cs2_n | input | 1 | Active-low chip select |
| cs3 | input | 1 | Active-high chip select |
| oe_n | input | 1 | Asynchronous active-low output enable |
| din | input | LANES*LANE_W | Write data, taken two enabled edges after its address |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_en | output | 1 | High when `dout` carries valid read data |

## Verification
The bench builds the block with ADDR_W=4, LANES=2 and LANE_W=8, so the memory has sixteen 16-bit words. With this size every address can be written and read back in full. Every lane mask can be applied, and every burst start offset can be run in every aligned group of four. All eight chip-select combinations can be tried against the same word. An arithmetic model in the bench follows each enabled edge and predicts every output cycle, including cycles stalled by clock enable or snooze.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Wrapping step of the two-bit burst counter (linear order, modulo 4).
  function automatic logic [1:0] ctr_step(input logic [1:0] c);
    return c + 2'd1;
  endfunction

  // All three chip selects must be in their active state.
  function automatic logic chip_selected(input logic sel_a_n, input logic sel_b_n,
                                         input logic sel_c);
    return !sel_a_n && !sel_b_n && sel_c;
  endfunction

endpackage

// File: rtl/psr_burst.sv
module psr_burst
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              ld_n,
  input  logic              rd_wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  ben_n,
  input  logic              cs1_n,
  input  logic              cs2_n,
  input  logic              cs3,
  output op_e               iss_op,
  output logic [ADDR_W-1:0] iss_addr,
  output logic [LANES-1:0]  iss_ben,
  output logic [1:0]        burst_ctr,
  output logic              burst_live
);

  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] base_q;
  logic [1:0]      ctr_q;
  logic            live_q;
  logic            wr_q;
  logic            sel;
  logic [1:0]      ctr_nxt;

  assign sel     = chip_selected(cs1_n, cs2_n, cs3);
  assign ctr_nxt = ctr_step(ctr_q);

  always_comb begin
    iss_ben = ben_n;
    if (!ld_n) begin
      iss_addr = addr;
      if (sel) iss_op = rd_wr_n ? OP_READ : OP_WRITE;
      else     iss_op = OP_IDLE;
    end else begin
      iss_addr = {base_q, ctr_nxt};
      if (live_q) iss_op = wr_q ? OP_WRITE : OP_READ;
      else        iss_op = OP_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      ctr_q  <= 2'd0;
    end else if (step) begin
      if (!ld_n) begin
        live_q <= sel;
        wr_q   <= !rd_wr_n;
        base_q <= addr[ADDR_W-1:2];
        ctr_q  <= addr[1:0];
      end else if (live_q) begin
        ctr_q <= ctr_nxt;
      end
    end
  end

  assign burst_ctr  = ctr_q;
  assign burst_live = live_q;

endmodule

// File: rtl/psr_pipe.sv
module psr_pipe
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  op_e               in_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [LANES-1:0]  in_ben,
  output op_e               out_op,
  output logic [ADDR_W-1:0] out_addr,
  output logic [LANES-1:0]  out_ben
);

  op_e               op_q   [STAGES];
  logic [ADDR_W-1:0] addr_q [STAGES];
  logic [LANES-1:0]  ben_q  [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          op_q[g]   <= OP_IDLE;
          addr_q[g] <= '0;
          ben_q[g]  <= '1;
        end else if (step) begin
          op_q[g]   <= in_op;
          addr_q[g] <= in_addr;
          ben_q[g]  <= in_ben;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          op_q[g]   <= OP_IDLE;
          addr_q[g] <= '0;
          ben_q[g]  <= '1;
        end else if (step) begin
          op_q[g]   <= op_q[g-1];
          addr_q[g] <= addr_q[g-1];
          ben_q[g]  <= ben_q[g-1];
        end
      end
    end
  end

  assign out_op   = op_q[STAGES-1];
  assign out_addr = addr_q[STAGES-1];
  assign out_ben  = ben_q[STAGES-1];

endmodule

// File: rtl/psr_array.sv
module psr_array
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  input  op_e                     op,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        ben_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rvalid,
  output logic                    wr_fire,
  output logic                    rd_fire
);

  localparam int DW    = LANES * LANE_W;
  localparam int WORDS = 1 << ADDR_W;

  logic [DW-1:0] mem [WORDS];

  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_w,
                                                input logic [DW-1:0] new_w,
                                                input logic [LANES-1:0] keep_n);
    logic [DW-1:0] r;
    r = old_w;
    for (int l = 0; l < LANES; l++) begin
      if (!keep_n[l]) r[l*LANE_W +: LANE_W] = new_w[l*LANE_W +: LANE_W];
    end
    return r;
  endfunction

  assign wr_fire = step && (op == OP_WRITE);
  assign rd_fire = step && (op == OP_READ);

  always_ff @(posedge clk) begin
    if (wr_fire) mem[addr] <= lane_merge(mem[addr], din, ben_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (step) begin
      rvalid <= rd_fire;
      if (rd_fire) rdata <= mem[addr];
    end
  end

endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cken_n,
  input  logic                    sleep,
  input  logic                    ld_n,
  input  logic                    rd_wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        ben_n,
  input  logic                    cs1_n,
  input  logic                    cs2_n,
  input  logic                    cs3,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);

  localparam int DW      = LANES * LANE_W;
  localparam int LATENCY = 2;

  // Named internal events, observed by the bound checker.
  logic              step;
  op_e               iss_op;
  logic [ADDR_W-1:0] iss_addr;
  logic [LANES-1:0]  iss_ben;
  logic [1:0]        burst_ctr;
  logic              burst_live;
  op_e               cmt_op;
  logic [ADDR_W-1:0] cmt_addr;
  logic [LANES-1:0]  cmt_ben;
  logic [DW-1:0]     rdata_w;
  logic              rvalid_w;
  logic              wr_fire;
  logic              rd_fire;

  assign step = !cken_n && !sleep;

  psr_burst #(.ADDR_W(ADDR_W), .LANES(LANES)) u_burst (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .ld_n      (ld_n),
    .rd_wr_n   (rd_wr_n),
    .addr      (addr),
    .ben_n     (ben_n),
    .cs1_n     (cs1_n),
    .cs2_n     (cs2_n),
    .cs3       (cs3),
    .iss_op    (iss_op),
    .iss_addr  (iss_addr),
    .iss_ben   (iss_ben),
    .burst_ctr (burst_ctr),
    .burst_live(burst_live)
  );

  psr_pipe #(.ADDR_W(ADDR_W), .LANES(LANES), .STAGES(LATENCY)) u_pipe (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (step),
    .in_op   (iss_op),
    .in_addr (iss_addr),
    .in_ben  (iss_ben),
    .out_op  (cmt_op),
    .out_addr(cmt_addr),
    .out_ben (cmt_ben)
  );

  psr_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (step),
    .op     (cmt_op),
    .addr   (cmt_addr),
    .ben_n  (cmt_ben),
    .din    (din),
    .rdata  (rdata_w),
    .rvalid (rvalid_w),
    .wr_fire(wr_fire),
    .rd_fire(rd_fire)
  );

  assign dout_en = rvalid_w && !oe_n && !sleep;
  assign dout    = dout_en ? rdata_w : '0;

endmodule

// File: rtl/psr_checks.sv
module psr_checks
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 2,
  parameter int LANE_W = 9
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    step,
  input logic                    ld_n,
  input logic                    sleep,
  input logic                    oe_n,
  input logic                    cs1_n,
  input logic                    cs2_n,
  input logic                    cs3,
  input logic                    dout_en,
  input logic [LANES*LANE_W-1:0] dout,
  input op_e                     iss_op,
  input logic [ADDR_W-1:0]       iss_addr,
  input logic [1:0]              burst_ctr,
  input logic                    burst_live,
  input logic                    rvalid_w,
  input logic [LANES*LANE_W-1:0] rdata_w,
  input logic                    rd_fire,
  input logic                    wr_fire
);

  // R1: a committed read raises the valid flag on the next edge
  p_read_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rvalid_w);

  // R2: a committed write produces no read data
  p_write_no_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !rvalid_w);

  // R4: a continue in a live burst moves the counter by one, wrapping
  p_burst_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ld_n && burst_live) |=> (burst_ctr == $past(burst_ctr) + 2'd1));

  // R4: the issued low address bits equal the next counter value
  p_burst_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_n && burst_live) |-> (iss_addr[1:0] == burst_ctr + 2'd1));

  // R5: a load with any select inactive issues nothing
  p_desel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_n && !(!cs1_n && !cs2_n && cs3)) |-> (iss_op == OP_IDLE));

  // R6: continue after deselect issues nothing and leaves the counter alone
  p_dead_cont_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ld_n && !burst_live) |=> ($stable(burst_ctr) && !burst_live));

  // R7: a stalled edge holds output data, valid flag and counter
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(rdata_w) && $stable(rvalid_w) && $stable(burst_ctr)));

  // R8: snooze keeps the output drive off
  p_sleep_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dout_en);

  // R9: output enable high means no drive and zero data
  p_oe_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (!dout_en && (dout == '0)));

  // R10: reset leaves no read data pending
  p_reset_clear_r10: assert property (@(posedge clk)
    !rst_n |=> !rvalid_w);

endmodule

bind pipe_sram psr_checks #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_checks (
  .clk       (clk),
  .rst_n     (rst_n),
  .step      (step),
  .ld_n      (ld_n),
  .sleep     (sleep),
  .oe_n      (oe_n),
  .cs1_n     (cs1_n),
  .cs2_n     (cs2_n),
  .cs3       (cs3),
  .dout_en   (dout_en),
  .dout      (dout),
  .iss_op    (iss_op),
  .iss_addr  (iss_addr),
  .burst_ctr (burst_ctr),
  .burst_live(burst_live),
  .rvalid_w  (rvalid_w),
  .rdata_w   (rdata_w),
  .rd_fire   (rd_fire),
  .wr_fire   (wr_fire)
);

// File: tb/pipe_sram_test.sv
`timescale 1ns/1ps
module pipe_sram_test;

  localparam int AW = 4;
  localparam int NL = 2;
  localparam int LW = 8;
  localparam int DW = NL * LW;
  localparam logic [2:0] SEL = 3'b100;  // {cs3, cs2_n, cs1_n}

  logic clk = 1'b0;
  logic rst_n, cken_n, sleep, ld_n, rd_wr_n, cs1_n, cs2_n, cs3, oe_n;
  logic [AW-1:0] addr;
  logic [NL-1:0] ben_n;
  logic [DW-1:0] din, dout;
  logic dout_en;

  always #2.5 clk = ~clk;

  pipe_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .cken_n(cken_n), .sleep(sleep), .ld_n(ld_n),
    .rd_wr_n(rd_wr_n), .addr(addr), .ben_n(ben_n), .cs1_n(cs1_n), .cs2_n(cs2_n),
    .cs3(cs3), .oe_n(oe_n), .din(din), .dout(dout), .dout_en(dout_en)
  );

  int checks = 0;
  int fails  = 0;
  int nstep  = 0;
  bit done   = 0;

  // Bench reference model
  logic [DW-1:0] ref_mem [16];
  logic          bact = 0, bwr = 0;
  logic [1:0]    bbase = 0, bcnt = 0;
  int            p_op [2] = '{0, 0};
  int            p_a  [2] = '{0, 0};
  logic [NL-1:0] p_b  [2] = '{2'b11, 2'b11};
  logic          mval = 0;
  logic [DW-1:0] mdata = '0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_edge(input logic ld, input logic rw, input int a,
                            input logic [NL-1:0] ben, input logic [2:0] cs);
    int nop, na;
    logic sel;
    sel = !cs[0] && !cs[1] && cs[2];
    nop = 0; na = 0;
    if (!ld) begin
      na = a;
      if (sel) begin
        nop = rw ? 1 : 2;
        bact = 1; bwr = !rw; bbase = a[3:2]; bcnt = a[1:0];
      end else bact = 0;
    end else if (bact) begin
      bcnt = bcnt + 2'd1;
      na = int'({bbase, bcnt});
      nop = bwr ? 2 : 1;
    end
    mval = 0;
    if (p_op[1] == 2) begin
      for (int l = 0; l < NL; l++)
        if (!p_b[1][l]) ref_mem[p_a[1]][l*LW +: LW] = din[l*LW +: LW];
    end else if (p_op[1] == 1) begin
      mval = 1;
      mdata = ref_mem[p_a[1]];
    end
    p_op[1] = p_op[0]; p_a[1] = p_a[0]; p_b[1] = p_b[0];
    p_op[0] = nop;     p_a[0] = na;     p_b[0] = ben;
  endtask

  task automatic step(input logic ld, input logic rw, input int a, input logic [NL-1:0] ben,
                      input logic [2:0] cs, input logic ck, input logic sl, input logic oe,
                      input string tag);
    logic exp_en;
    ld_n = ld; rd_wr_n = rw; addr = a[AW-1:0]; ben_n = ben;
    cs1_n = cs[0]; cs2_n = cs[1]; cs3 = cs[2];
    cken_n = ck; sleep = sl; oe_n = oe;
    din = 16'(nstep * 40861 + 3870);
    nstep++;
    @(posedge clk);
    if (!ck && !sl) model_edge(ld, rw, a, ben, cs);
    @(negedge clk);
    exp_en = mval && !oe && !sl;
    chk({tag, " dout_en"}, {15'd0, dout_en}, {15'd0, exp_en});
    chk({tag, " dout"}, dout, exp_en ? mdata : '0);
  endtask

  task automatic wr(input int a, input logic [NL-1:0] ben, input string tag);
    step(0, 0, a, ben, SEL, 0, 0, 0, tag);
  endtask
  task automatic rd(input int a, input string tag);
    step(0, 1, a, 2'b11, SEL, 0, 0, 0, tag);
  endtask
  task automatic cont(input logic rw, input logic [NL-1:0] ben, input string tag);
    step(1, rw, 9, ben, 3'b011, 0, 0, 0, tag);  // selects held inactive: ignored
  endtask
  task automatic nop(input string tag);
    step(0, 0, 6, 2'b00, 3'b000, 0, 0, 0, tag);  // deselected load
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cken_n = 0; sleep = 0; ld_n = 0; rd_wr_n = 1; addr = '0; ben_n = '1;
    cs1_n = 1; cs2_n = 1; cs3 = 0; oe_n = 0; din = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 reset dout_en", {15'd0, dout_en}, 16'd0);
    chk("R10 reset dout", dout, 16'd0);
    rst_n = 1;

    // R2: full writes to every word, then R1 read-back of every word
    for (int a = 0; a < 16; a++) wr(a, 2'b00, "R2");
    nop("R2"); nop("R2");
    for (int a = 0; a < 16; a++) rd(a, "R1");
    nop("R1"); nop("R1");

    // R3: write then read of the same word on the next edge, and mixed
    for (int a = 0; a < 16; a++) begin
      wr(a, 2'b00, "R3");
      rd(a, "R3");
      rd(a ^ 1, "R3");
      wr(15 - a, 2'b00, "R3");
    end
    nop("R3"); nop("R3");

    // R2: every lane mask on every word, then read back
    for (int a = 0; a < 16; a++) wr(a, 2'(a % 4), "R2");
    for (int a = 0; a < 16; a++) rd(a, "R2");
    nop("R2"); nop("R2");

    // R4: bursts from every offset in every group; rd_wr_n flipped on continues
    for (int b = 0; b < 4; b++) begin
      for (int s = 0; s < 4; s++) begin
        wr(b * 4 + s, 2'b00, "R4");
        for (int k = 0; k < 3; k++) cont(1, 2'(k + s), "R4");
        rd(b * 4 + s, "R4");
        for (int k = 0; k < 3; k++) cont(0, 2'b00, "R4");
      end
    end
    nop("R4"); nop("R4");
    for (int a = 0; a < 16; a++) rd(a, "R4");
    nop("R4"); nop("R4");

    // R5: every non-selecting combination on a write load to word 5
    for (int c = 0; c < 8; c++) begin
      if (3'(c) != SEL) step(0, 0, 5, 2'b00, 3'(c), 0, 0, 0, "R5");
    end
    nop("R5"); rd(5, "R5"); nop("R5"); nop("R5");

    // R6: continues after a deselected load do nothing
    nop("R6"); cont(0, 2'b00, "R6"); cont(1, 2'b00, "R6"); cont(0, 2'b00, "R6");
    for (int a = 4; a < 12; a++) rd(a, "R6");
    nop("R6"); nop("R6");

    // R7: stalls in the middle of a write burst and a read burst
    wr(8, 2'b00, "R7");
    cont(0, 2'b00, "R7");
    step(0, 1, 3, 2'b00, SEL, 1, 0, 0, "R7");
    step(0, 0, 7, 2'b00, SEL, 1, 0, 0, "R7");
    cont(0, 2'b01, "R7"); cont(0, 2'b10, "R7");
    rd(8, "R7"); cont(0, 2'b00, "R7"); cont(0, 2'b00, "R7");
    step(0, 0, 1, 2'b00, SEL, 1, 0, 0, "R7");
    step(1, 0, 2, 2'b00, SEL, 1, 0, 0, "R7");
    cont(1, 2'b00, "R7");
    step(0, 0, 1, 2'b00, SEL, 1, 0, 0, "R7");
    nop("R7"); nop("R7");

    // R8: snooze mid read burst with a would-be write presented
    rd(12, "R8"); cont(0, 2'b00, "R8");
    step(0, 0, 12, 2'b00, SEL, 0, 1, 0, "R8");
    step(1, 0, 13, 2'b00, SEL, 0, 1, 0, "R8");
    cont(0, 2'b00, "R8"); cont(0, 2'b00, "R8");
    nop("R8"); nop("R8");
    for (int a = 12; a < 16; a++) rd(a, "R8");
    nop("R8"); nop("R8");

    // R9: output enable gating, clocked and asynchronous
    rd(3, "R9"); rd(4, "R9");
    step(0, 1, 5, 2'b11, SEL, 0, 0, 1, "R9");
    nop("R9");
    nop("R9");
    oe_n = 1; #1;
    chk("R9 async off", {15'd0, dout_en}, 16'd0);
    chk("R9 async data", dout, 16'd0);
    oe_n = 0; #1;
    chk("R9 async on", {15'd0, dout_en}, {15'd0, mval});
    chk("R9 async back", dout, mval ? mdata : '0);
    nop("R9"); nop("R9");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule